// File: doc/BRIEF.md
# Hit Count Readout Formatter

When a trigger accept arrives, this block takes a snapshot of the per-channel hit counts, the channel enable mask and the board identity fields. It then writes a burst of seven 32-bit words into a downstream count buffer, one word per clock. The first word is a header. It carries the current bunch number, the slot (geographical) address, a 10-bit chip serial number and a 9-bit chip type. The six words after it each pack eight 4-bit channel fields. Each field holds a count limited to 4 and a flag that says whether the channel is enabled.

The block also keeps its own 8-bit bunch counter. A bunch-zero marker loads a programmable offset into it. Each bunch clock enable advances it by one. The header reports the counter value as it stood when the trigger was accepted. Counting the hits and holding the buffer memory are done elsewhere. This block only forms the words and presents them with a write strobe and a word address.

Top module: `hitcnt_formatter`

## Requirements
- R1: After a trigger is accepted on a clock edge, seven writes follow on the next seven consecutive cycles. The word address counts 0,1,…,6, and the first write appears in the cycle right after the accepting edge.
- R2: `busy` is high for exactly the seven write cycles. `buf_we` is high only while `busy` is high.
- R3: Header word (address 0) bits [7:0] equal the bunch counter value in the cycle the trigger was accepted.
- R4: Header word bits [12:8] hold the geographical address, bits [22:13] the serial number and bits [31:23] the chip type, all as sampled at the accepting edge.
- R5: Count word at address k (1..6) holds channel 8·(k−1)+j in bits [4j+3:4j], for j = 0..7.
- R6: In each channel field, bit 3 equals the channel's enable-mask bit. Bits [2:0] equal the channel's input count when it is 4 or less, and 4 otherwise.
- R7: The bunch counter loads the offset on a bunch-zero marker, and the marker wins over a simultaneous enable. Otherwise it adds one on each enable and wraps from 255 to 0.
- R8: A trigger that arrives while `busy` is high is ignored. Input changes after the accepting edge do not alter any word of the burst in progress.
- R9: After reset, `busy` and `buf_we` are low and the bunch counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_en | input | 1 | Bunch clock enable, advances the bunch counter |
| bx_zero | input | 1 | Bunch-zero marker, loads the offset |
| bid_offset | input | 8 | Value loaded into the bunch counter at bunch zero |
| trig | input | 1 | Trigger accept request |
| hit_cnt | input | NUM_CH*CNT_IN_W | Raw hit count per channel, channel c at [c*CNT_IN_W +: CNT_IN_W] |
| ch_enable | input | NUM_CH | Per-channel enable mask |
| geo_addr | input | 5 | Geographical slot address |
| serial_no | input | 10 | Chip serial number |
| chip_type | input | 9 | Chip type code |
| buf_we | output | 1 | Count buffer write strobe |
| buf_addr | output | 3 | Word address within the burst |
| buf_data | output | 32 | Word to write |
| busy | output | 1 | High while a burst is being written |

## Verification
The bench first sends counts above 4, including 15, and checks that each is limited to exactly 4. A design that only masked the low three bits would report 7 or 0 here. It then wraps the bunch counter past 255 and asserts bunch-zero and enable in the same cycle. A wrong priority or a missing wrap would show up as a header bunch ID that is off by one, or one that is far too large. It also holds the trigger high continuously and pulses it in the middle of a burst, while changing the mask and the counts during the burst. A design that re-triggers or reads live inputs would then make extra writes or send altered words. Finally, it drives the identity fields to all ones and to alternating patterns, which exposes any shifted header bit field.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    localparam int WORD_W  = 32;
    localparam int NIB_W   = 4;
    localparam int BID_W   = 8;
    localparam int GEO_W   = 5;
    localparam int SER_W   = 10;
    localparam int TYPE_W  = 9;
    localparam int CNT_MAX = 4;
    localparam int CH_PER_WORD = WORD_W / NIB_W;

    // Header layout, most significant field first
    typedef struct packed {
        logic [TYPE_W-1:0] chip_type;
        logic [SER_W-1:0]  serial;
        logic [GEO_W-1:0]  geo;
        logic [BID_W-1:0]  bunch;
    } header_t;

    typedef struct packed {
        logic       on;
        logic [2:0] cnt;
    } nibble_t;

    function automatic nibble_t make_nibble(input logic en, input logic [7:0] raw);
        nibble_t n;
        n.on  = en;
        n.cnt = (raw > 8'(CNT_MAX)) ? 3'(CNT_MAX) : raw[2:0];
        return n;
    endfunction

    function automatic logic word_fields_ok(input logic [WORD_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int j = 0; j < CH_PER_WORD; j++) begin
            if (w[j*NIB_W +: 3] > 3'(CNT_MAX)) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/hcf_bunch_ctr.sv
module hcf_bunch_ctr
    import hcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bx_en,
    input  logic             bx_zero,
    input  logic [BID_W-1:0] offset,
    output logic [BID_W-1:0] bunch
);

    always_ff @(posedge clk) begin
        if (rst)          bunch <= '0;
        else if (bx_zero) bunch <= offset;
        else if (bx_en)   bunch <= bunch + 1'b1;
    end

    // R7
    bunch_load_chk: assert property (@(posedge clk) disable iff (rst)
        bx_zero |=> bunch == $past(offset));

    // R7
    bunch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bx_en && !bx_zero) |=> bunch == BID_W'($past(bunch) + 1'b1));

    // R7
    bunch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bx_en && !bx_zero) |=> $stable(bunch));

endmodule

// File: rtl/hcf_capture.sv
module hcf_capture
    import hcf_pkg::*;
#(
    parameter int NUM_CH   = 48,
    parameter int CNT_IN_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       take,
    input  logic [NUM_CH*CNT_IN_W-1:0] hit_cnt,
    input  logic [NUM_CH-1:0]          ch_enable,
    input  logic [BID_W-1:0]           bunch,
    input  logic [GEO_W-1:0]           geo_addr,
    input  logic [SER_W-1:0]           serial_no,
    input  logic [TYPE_W-1:0]          chip_type,
    output header_t                    hdr,
    output logic [NUM_CH*NIB_W-1:0]    nibs
);

    logic [NUM_CH*NIB_W-1:0] nibs_next;

    // One formatter per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            nibs_next[c*NIB_W +: NIB_W] =
                make_nibble(ch_enable[c], 8'(hit_cnt[c*CNT_IN_W +: CNT_IN_W]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr  <= '0;
            nibs <= '0;
        end else if (take) begin
            hdr.chip_type <= chip_type;
            hdr.serial    <= serial_no;
            hdr.geo       <= geo_addr;
            hdr.bunch     <= bunch;
            nibs          <= nibs_next;
        end
    end

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(nibs) && $stable(hdr)));

endmodule

// File: rtl/hcf_sequencer.sv
module hcf_sequencer #(
    parameter int NUM_WORDS = 7,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    output logic             take,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

    assign take = trig && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST) busy <= 1'b0;
            else             idx  <= idx + 1'b1;
        end
    end

    // R1
    burst_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (idx == '0 && $past(trig)));

    // R1
    burst_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == LAST) |=> !busy);

    // R8
    no_retrig_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST && trig) |=> idx != '0);

endmodule

// File: rtl/hitcnt_formatter.sv
module hitcnt_formatter
    import hcf_pkg::*;
#(
    parameter int NUM_CH   = 48,
    parameter int CNT_IN_W = 4,
    localparam int NUM_CW    = NUM_CH / CH_PER_WORD,
    localparam int NUM_WORDS = NUM_CW + 1,
    localparam int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bx_en,
    input  logic                       bx_zero,
    input  logic [BID_W-1:0]           bid_offset,
    input  logic                       trig,
    input  logic [NUM_CH*CNT_IN_W-1:0] hit_cnt,
    input  logic [NUM_CH-1:0]          ch_enable,
    input  logic [GEO_W-1:0]           geo_addr,
    input  logic [SER_W-1:0]           serial_no,
    input  logic [TYPE_W-1:0]          chip_type,
    output logic                       buf_we,
    output logic [IDX_W-1:0]           buf_addr,
    output logic [WORD_W-1:0]          buf_data,
    output logic                       busy
);

    logic [BID_W-1:0]        bunch;
    logic                    take;
    logic [IDX_W-1:0]        idx;
    header_t                 hdr;
    logic [NUM_CH*NIB_W-1:0] nibs;
    logic [WORD_W-1:0]       cnt_words [NUM_CW];

    hcf_bunch_ctr u_bunch (
        .clk     (clk),
        .rst     (rst),
        .bx_en   (bx_en),
        .bx_zero (bx_zero),
        .offset  (bid_offset),
        .bunch   (bunch)
    );

    hcf_sequencer #(.NUM_WORDS(NUM_WORDS)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .take (take),
        .busy (busy),
        .idx  (idx)
    );

    hcf_capture #(.NUM_CH(NUM_CH), .CNT_IN_W(CNT_IN_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .hit_cnt   (hit_cnt),
        .ch_enable (ch_enable),
        .bunch     (bunch),
        .geo_addr  (geo_addr),
        .serial_no (serial_no),
        .chip_type (chip_type),
        .hdr       (hdr),
        .nibs      (nibs)
    );

    for (genvar w = 0; w < NUM_CW; w++) begin : g_word
        assign cnt_words[w] = nibs[w*WORD_W +: WORD_W];
    end

    always_comb begin
        buf_data = hdr;
        for (int w = 0; w < NUM_CW; w++) begin
            if (idx == IDX_W'(w + 1)) buf_data = cnt_words[w];
        end
    end

    assign buf_we   = busy;
    assign buf_addr = idx;

    // R6
    field_range_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_we && buf_addr != '0) |-> word_fields_ok(buf_data));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!buf_we && bunch == '0));

endmodule

// File: tb/test_hitcnt_formatter.sv
module test_hitcnt_formatter;

    localparam int NUM_CH = 48;
    localparam int CW     = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bx_en = 1'b0, bx_zero = 1'b0, trig = 1'b0;
    logic [7:0] bid_offset = '0;
    logic [NUM_CH*CW-1:0] hit_cnt = '0;
    logic [NUM_CH-1:0] ch_enable = '0;
    logic [4:0] geo_addr = '0;
    logic [9:0] serial_no = '0;
    logic [8:0] chip_type = '0;
    logic buf_we, busy;
    logic [2:0] buf_addr;
    logic [31:0] buf_data;

    int checks = 0, errors = 0;
    int cyc = 0;
    int model_bid = 0, model_busy = 0;
    bit done = 0;

    int          q_stamp [$];
    logic [2:0]  q_addr  [$];
    logic [31:0] q_data  [$];

    always #5 clk = ~clk;

    hitcnt_formatter #(.NUM_CH(NUM_CH), .CNT_IN_W(CW)) i_hitcnt_formatter (
        .clk(clk), .rst(rst), .bx_en(bx_en), .bx_zero(bx_zero),
        .bid_offset(bid_offset), .trig(trig), .hit_cnt(hit_cnt),
        .ch_enable(ch_enable), .geo_addr(geo_addr), .serial_no(serial_no),
        .chip_type(chip_type), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_data(buf_data), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected-word model from the requirements (R3 R4 R5 R6 R7)
    function automatic logic [31:0] exp_word(input int k);
        logic [31:0] w;
        if (k == 0) begin
            w = {chip_type, serial_no, geo_addr, 8'(model_bid)};
        end else begin
            w = '0;
            for (int j = 0; j < 8; j++) begin
                int c;
                int raw;
                c = 8 * (k - 1) + j;
                raw = int'(hit_cnt[c*CW +: CW]);
                w[4*j +: 4] = {ch_enable[c], 3'(raw > 4 ? 4 : raw)};
            end
        end
        return w;
    endfunction

    // Driver-side model: pushes expected items on each accepted trigger
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            model_bid = 0;
            model_busy = 0;
        end else begin
            if (trig && model_busy == 0) begin
                for (int k = 0; k < 7; k++) begin
                    q_stamp.push_back(cyc + k);
                    q_addr.push_back(3'(k));
                    q_data.push_back(exp_word(k));
                end
                model_busy = 7;
            end else if (model_busy > 0) begin
                model_busy--;
            end
            if (bx_zero)    model_bid = int'(bid_offset);
            else if (bx_en) model_bid = (model_bid + 1) % 256;
        end
    end

    // Monitor: compares design writes with the queue
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (busy !== buf_we) check(0, "R2", {31'b0, buf_we}, {31'b0, busy});
            if (buf_we) begin
                if (q_data.size() == 0) begin
                    check(0, "R8", {29'b0, buf_addr}, 32'hFFFF_FFFF);
                end else begin
                    int st;
                    logic [2:0] ea;
                    logic [31:0] ed;
                    st = q_stamp.pop_front();
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    check(st == cyc, "R1", cyc, st);
                    check(buf_addr == ea, "R1", {29'b0, buf_addr}, {29'b0, ea});
                    if (ea == 0) check(buf_data == ed, "R3/R4", buf_data, ed);
                    else         check(buf_data == ed, "R5/R6", buf_data, ed);
                end
            end else if (q_stamp.size() != 0 && q_stamp[0] < cyc) begin
                check(0, "R2", 32'd0, 32'd1);
                void'(q_stamp.pop_front());
                void'(q_addr.pop_front());
                void'(q_data.pop_front());
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire();
        trig = 1'b1; tick(1); trig = 1'b0;
    endtask

    task automatic set_counts(input int seed);
        for (int c = 0; c < NUM_CH; c++) hit_cnt[c*CW +: CW] = 4'((c * seed + seed) % 16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R9: reset state
        check(busy == 0 && buf_we == 0, "R9", {30'b0, busy, buf_we}, 32'd0);
        // R9: counter 0 after reset, seen in the header
        geo_addr = 5'h0A; serial_no = 10'h155; chip_type = 9'h0AA; ch_enable = '1;
        set_counts(1);
        fire(); tick(9);

        // R7: load offset, then three increments
        bid_offset = 8'h10; bx_zero = 1; tick(1); bx_zero = 0;
        bx_en = 1; tick(3); bx_en = 0;
        set_counts(3); ch_enable = 48'hAAAA_5555_F0F0;
        fire(); tick(9);

        // R6: counts all above 4, and all zero
        hit_cnt = '1; ch_enable = '0; fire(); tick(9);
        hit_cnt = '0; ch_enable = '1; fire(); tick(9);

        // R8: retrigger and input changes during a burst
        set_counts(5); fire(); tick(2);
        trig = 1; set_counts(7); ch_enable = 48'h0123_4567_89AB; geo_addr = 5'h1F; tick(1); trig = 0;
        tick(2); fire(); tick(8);

        // R7: wrap 250 + 10 -> 4, bunch ID advancing during the burst
        bid_offset = 8'hFA; bx_zero = 1; tick(1); bx_zero = 0;
        bx_en = 1; tick(10);
        trig = 1; tick(1); trig = 0; tick(8); bx_en = 0;

        // R7: bunch-zero wins over a simultaneous enable
        bid_offset = 8'h33; bx_zero = 1; bx_en = 1; tick(1); bx_zero = 0; bx_en = 0;
        fire(); tick(9);

        // R4: extreme identity fields
        geo_addr = '1; serial_no = '1; chip_type = '1; fire(); tick(9);
        geo_addr = '0; serial_no = 10'h2AA; chip_type = 9'h155; fire(); tick(9);

        // R1/R8: trigger held high, back-to-back bursts
        set_counts(11); trig = 1; tick(20); trig = 0; tick(10);

        // R1: every expected word was written
        check(q_data.size() == 0, "R1", q_data.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule